// File: doc/BRIEF.md
# Relative-vertex drawing command decoder

This block sits in front of a 2D drawing engine and turns one drawing command into a checked parameter set and a stream of absolute vertices. The command arrives as 32-bit words over a valid/ready handshake. The first word carries the command code and the mode flags. Four header words follow. They hold the base address, the texture dimensions, the texture offset with the vertex count, and the line width. The block then checks every header field against its legal range and against the rules that link fields to each other.

A header that passes the checks is published with a one-cycle `hdrValid` pulse. The block then reads the displacement words. Each one holds two relative X/Y steps as signed bytes. Each step is sign-extended and added to a running 16-bit position that starts at `startX`/`startY`. The result is emitted as one absolute vertex per step. A command that fails a check is reported with an `err` pulse and an error code, and the block returns to waiting for a command word. Rendering, memory access and texture sampling are left to downstream logic.

Top module: `relvtx_decoder`

## Requirements
- R1: A word taken while idle starts a command only when bits [31:24] equal 8'hB6. Any other value is consumed and produces `err` for one cycle, starting the cycle after acceptance, with `errCode` = 8'h01 (bit 0). The block stays idle afterwards.
- R2: The four words that follow the command word are decoded in this order:
  - the base address (all 32 bits);
  - texture width in [27:16] and texture height in [11:0];
  - texture offset in [27:16] and vertex count n in [15:0];
  - line width in [5:0].
  The mode flags come from bits [15:0] of the command word. For a legal header, `hdrValid` pulses for one cycle, two cycles after the line-width word is accepted, with all fields on their outputs.
- R3: n = 0 is rejected with `errCode` bit 1.
- R4: A texture width outside 8..4088, or a texture height of 0, sets `errCode` bit 2. A texture offset greater than width-1 sets bit 3.
- R5: A line width of 1 sets `errCode` bit 4. A line width of 0 combined with a texture height other than 1 sets bit 5.
- R6: If `cmdAddrOdd` XOR bit 0 of the base address is 1 (an odd 32-bit-word sum, not 64-bit aligned), `errCode` bit 6 is set.
- R7: The mode flags must have bit 0 (relative) = 1, bit 4 (style) = 1 and bit 3 (sub-sampling) = 0. Otherwise `errCode` bit 7 is set.
- R8: Each displacement word carries, from the least significant byte up: DY(k), DX(k), DY(k+1), DX(k+1), all signed 8-bit. Each vertex equals the previous position plus the sign-extended step. The position starts at `startX`/`startY`, which are sampled with the command word, and wraps modulo 2^16.
- R9: For odd n, the upper half of the final displacement word is consumed but produces no vertex, whatever its content.
- R10: While `vtxValid` is high, `vtxX`, `vtxY` and `vtxLast` hold until `vtxReady`, and `inReady` is low.
- R11: `vtxLast` is high on the n-th vertex only. `done` pulses for one cycle, in the cycle after that vertex's handshake. A following command word is then accepted.
- R12: A synchronous reset, applied at any point, leaves `inReady` = 1 and `vtxValid`, `done`, `err` and `hdrValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Command word offered |
| inReady | output | 1 | Command word can be taken |
| inData | input | 32 | Command word |
| cmdAddrOdd | input | 1 | Bit 0 of the command's 32-bit-word address, sampled with the command word |
| startX | input | 16 | Initial X position, sampled with the command word |
| startY | input | 16 | Initial Y position, sampled with the command word |
| hdrValid | output | 1 | One-cycle pulse: legal header decoded |
| modeFlags | output | 16 | Draw-mode flags |
| baseAddr | output | 32 | Base address in 32-bit words |
| texWidth | output | 12 | Texture width |
| texHeight | output | 12 | Texture height |
| texOffset | output | 12 | Texture offset |
| vtxCount | output | 16 | Vertex count n |
| lineWidth | output | 6 | Line width |
| vtxValid | output | 1 | Vertex offered |
| vtxReady | input | 1 | Vertex can be taken |
| vtxX | output | 16 | Absolute vertex X |
| vtxY | output | 16 | Absolute vertex Y |
| vtxLast | output | 1 | Marks the final vertex |
| done | output | 1 | One-cycle pulse after the final vertex |
| err | output | 1 | One-cycle pulse: command rejected |
| errCode | output | 8 | Reason bits for the last rejection |

## Verification
Each result is due at a fixed number of cycles after its stimulus:
- A rejected command word shows `err` one edge after acceptance.
- The header verdict (`hdrValid` or `err`) lands on the second edge after the line-width word.
- A vertex appears one edge after its displacement word is taken.
- `done` follows the final vertex handshake by exactly one edge.

The bench drives inputs between edges and samples at the falling edge. For the header verdict it checks that nothing is visible at the intermediate sample and that the verdict is present at the one after. For vertices it logs the cycle number of each handshake and of `done` and compares their distance. Vertex values are recomputed from the displacement table with byte order and wrap applied independently. This runs with and without random back-pressure on `vtxReady`.

// File: rtl/relvtx_pkg.sv
package relvtx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BASE, ST_TEX, ST_CNT, ST_LW, ST_CHK, ST_DISP, ST_EMIT_LO, ST_EMIT_HI
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capMode;
    logic capBase;
    logic capTex;
    logic capCnt;
    logic capLw;
    logic stepLo;
    logic stepHi;
    logic loadRem;
    logic decRem;
    logic setOpErr;
    logic setParamErr;
  } dpStrobe_t;

  localparam int ERR_W        = 8;
  localparam int ERR_OPCODE   = 0;
  localparam int ERR_CNT_ZERO = 1;
  localparam int ERR_TEX_SIZE = 2;
  localparam int ERR_OFFSET   = 3;
  localparam int ERR_LW_ONE   = 4;
  localparam int ERR_FLAT     = 5;
  localparam int ERR_ALIGN    = 6;
  localparam int ERR_MODE     = 7;

endpackage

// File: rtl/relvtx_ctrl.sv
module relvtx_ctrl
  import relvtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      vtxReady,
  input  logic      opOk,
  input  logic      paramBad,
  input  logic      remIsOne,
  output logic      inReady,
  output logic      vtxValid,
  output logic      hdrValid,
  output logic      done,
  output logic      err,
  output dpStrobe_t stb
);

  ctlState_t state, stateNxt;
  logic inFire, vtxFire;
  logic doneNxt, errNxt, hdrNxt;

  assign inReady  = (state == ST_IDLE) || (state == ST_BASE) || (state == ST_TEX) ||
                    (state == ST_CNT)  || (state == ST_LW)   || (state == ST_DISP);
  assign vtxValid = (state == ST_EMIT_LO) || (state == ST_EMIT_HI);
  assign inFire   = inValid && inReady;
  assign vtxFire  = vtxValid && vtxReady;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    doneNxt  = 1'b0;
    errNxt   = 1'b0;
    hdrNxt   = 1'b0;
    case (state)
      ST_IDLE: if (inFire) begin
        if (opOk) begin
          stb.capMode = 1'b1;
          stateNxt    = ST_BASE;
        end else begin
          stb.setOpErr = 1'b1;
          errNxt       = 1'b1;
        end
      end
      ST_BASE: if (inFire) begin stb.capBase = 1'b1; stateNxt = ST_TEX; end
      ST_TEX:  if (inFire) begin stb.capTex  = 1'b1; stateNxt = ST_CNT; end
      ST_CNT:  if (inFire) begin stb.capCnt  = 1'b1; stateNxt = ST_LW;  end
      ST_LW:   if (inFire) begin stb.capLw   = 1'b1; stateNxt = ST_CHK; end
      ST_CHK: begin
        if (paramBad) begin
          stb.setParamErr = 1'b1;
          errNxt          = 1'b1;
          stateNxt        = ST_IDLE;
        end else begin
          stb.loadRem = 1'b1;
          hdrNxt      = 1'b1;
          stateNxt    = ST_DISP;
        end
      end
      ST_DISP: if (inFire) begin stb.stepLo = 1'b1; stateNxt = ST_EMIT_LO; end
      ST_EMIT_LO: if (vtxFire) begin
        stb.decRem = 1'b1;
        if (remIsOne) begin
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          stb.stepHi = 1'b1;
          stateNxt   = ST_EMIT_HI;
        end
      end
      ST_EMIT_HI: if (vtxFire) begin
        stb.decRem = 1'b1;
        if (remIsOne) begin
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          stateNxt = ST_DISP;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      hdrValid <= 1'b0;
    end else begin
      state    <= stateNxt;
      done     <= doneNxt;
      err      <= errNxt;
      hdrValid <= hdrNxt;
    end
  end

endmodule

// File: rtl/relvtx_dp.sv
module relvtx_dp
  import relvtx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int COORD_W   = 16,
  parameter int DELTA_W   = 8,
  parameter int TEX_W     = 12,
  parameter int CNT_W     = 16,
  parameter int LW_W      = 6,
  parameter int MODE_W    = 16,
  parameter int OP_W      = 8,
  parameter logic [OP_W-1:0] OPCODE = 8'hB6,
  parameter int TEX_W_MIN = 8,
  parameter int TEX_W_MAX = 4088,
  parameter int REL_BIT   = 0,
  parameter int SUB_BIT   = 3,
  parameter int STYLE_BIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          stb,
  input  logic [WORD_W-1:0]  inData,
  input  logic               cmdAddrOdd,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  output logic               opOk,
  output logic               paramBad,
  output logic               remIsOne,
  output logic [MODE_W-1:0]  modeFlags,
  output logic [WORD_W-1:0]  baseAddr,
  output logic [TEX_W-1:0]   texWidth,
  output logic [TEX_W-1:0]   texHeight,
  output logic [TEX_W-1:0]   texOffset,
  output logic [CNT_W-1:0]   vtxCount,
  output logic [LW_W-1:0]    lineWidth,
  output logic [COORD_W-1:0] vtxX,
  output logic [COORD_W-1:0] vtxY,
  output logic [ERR_W-1:0]   errCode
);

  localparam int HALF_W  = 2 * DELTA_W;
  localparam int HI_POS  = WORD_W / 2;
  localparam int EXT_W   = COORD_W - DELTA_W;

  logic [MODE_W-1:0]  modeReg;
  logic [WORD_W-1:0]  baseReg;
  logic [TEX_W-1:0]   texWReg, texHReg, ofsReg;
  logic [CNT_W-1:0]   cntReg, remReg;
  logic [LW_W-1:0]    lwReg;
  logic               oddReg;
  logic [HALF_W-1:0]  hiHalf;
  logic [COORD_W-1:0] accX, accY;
  logic [ERR_W-1:0]   errReg, paramErr;
  logic [HALF_W-1:0]  pairSrc;
  logic [COORD_W-1:0] compExt [2];

  assign opOk    = inData[WORD_W-1 -: OP_W] == OPCODE;
  assign pairSrc = stb.stepHi ? hiHalf : inData[HALF_W-1:0];

  // component 0 = DY, component 1 = DX
  for (genvar g = 0; g < 2; g++) begin : g_sext
    assign compExt[g] = {{EXT_W{pairSrc[g*DELTA_W + DELTA_W-1]}}, pairSrc[g*DELTA_W +: DELTA_W]};
  end

  always_comb begin
    paramErr               = '0;
    paramErr[ERR_CNT_ZERO] = (cntReg == '0);
    paramErr[ERR_TEX_SIZE] = (texWReg < TEX_W'(TEX_W_MIN)) || (texWReg > TEX_W'(TEX_W_MAX)) ||
                             (texHReg == '0);
    paramErr[ERR_OFFSET]   = (ofsReg >= texWReg);
    paramErr[ERR_LW_ONE]   = (lwReg == LW_W'(1));
    paramErr[ERR_FLAT]     = (lwReg == '0) && (texHReg != TEX_W'(1));
    paramErr[ERR_ALIGN]    = oddReg ^ baseReg[0];
    paramErr[ERR_MODE]     = !modeReg[REL_BIT] || !modeReg[STYLE_BIT] || modeReg[SUB_BIT];
  end

  assign paramBad = |paramErr;
  assign remIsOne = (remReg == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= '0; baseReg <= '0; texWReg <= '0; texHReg <= '0; ofsReg <= '0;
      cntReg  <= '0; remReg  <= '0; lwReg   <= '0; oddReg  <= 1'b0; hiHalf <= '0;
      accX    <= '0; accY    <= '0; errReg  <= '0;
    end else begin
      if (stb.capMode) begin
        modeReg <= inData[MODE_W-1:0];
        oddReg  <= cmdAddrOdd;
        accX    <= startX;
        accY    <= startY;
      end
      if (stb.capBase) baseReg <= inData;
      if (stb.capTex) begin
        texWReg <= inData[HI_POS +: TEX_W];
        texHReg <= inData[0 +: TEX_W];
      end
      if (stb.capCnt) begin
        ofsReg <= inData[HI_POS +: TEX_W];
        cntReg <= inData[0 +: CNT_W];
      end
      if (stb.capLw) lwReg <= inData[0 +: LW_W];
      if (stb.stepLo) hiHalf <= inData[WORD_W-1 -: HALF_W];
      if (stb.stepLo || stb.stepHi) begin
        accX <= accX + compExt[1];
        accY <= accY + compExt[0];
      end
      if (stb.loadRem)     remReg <= cntReg;
      else if (stb.decRem) remReg <= remReg - CNT_W'(1);
      if (stb.setOpErr)         errReg <= ERR_W'(1) << ERR_OPCODE;
      else if (stb.setParamErr) errReg <= paramErr;
    end
  end

  assign modeFlags = modeReg;
  assign baseAddr  = baseReg;
  assign texWidth  = texWReg;
  assign texHeight = texHReg;
  assign texOffset = ofsReg;
  assign vtxCount  = cntReg;
  assign lineWidth = lwReg;
  assign vtxX      = accX;
  assign vtxY      = accY;
  assign errCode   = errReg;

endmodule

// File: rtl/relvtx_decoder.sv
module relvtx_decoder
  import relvtx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COORD_W = 16,
  parameter int TEX_W   = 12,
  parameter int CNT_W   = 16,
  parameter int LW_W    = 6,
  parameter int MODE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [WORD_W-1:0]  inData,
  input  logic               cmdAddrOdd,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  output logic               hdrValid,
  output logic [MODE_W-1:0]  modeFlags,
  output logic [WORD_W-1:0]  baseAddr,
  output logic [TEX_W-1:0]   texWidth,
  output logic [TEX_W-1:0]   texHeight,
  output logic [TEX_W-1:0]   texOffset,
  output logic [CNT_W-1:0]   vtxCount,
  output logic [LW_W-1:0]    lineWidth,
  output logic               vtxValid,
  input  logic               vtxReady,
  output logic [COORD_W-1:0] vtxX,
  output logic [COORD_W-1:0] vtxY,
  output logic               vtxLast,
  output logic               done,
  output logic               err,
  output logic [ERR_W-1:0]   errCode
);

  dpStrobe_t stb;
  logic opOk, paramBad, remIsOne;

  relvtx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .vtxReady (vtxReady),
    .opOk     (opOk),
    .paramBad (paramBad),
    .remIsOne (remIsOne),
    .inReady  (inReady),
    .vtxValid (vtxValid),
    .hdrValid (hdrValid),
    .done     (done),
    .err      (err),
    .stb      (stb)
  );

  relvtx_dp #(
    .WORD_W  (WORD_W),
    .COORD_W (COORD_W),
    .TEX_W   (TEX_W),
    .CNT_W   (CNT_W),
    .LW_W    (LW_W),
    .MODE_W  (MODE_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .inData     (inData),
    .cmdAddrOdd (cmdAddrOdd),
    .startX     (startX),
    .startY     (startY),
    .opOk       (opOk),
    .paramBad   (paramBad),
    .remIsOne   (remIsOne),
    .modeFlags  (modeFlags),
    .baseAddr   (baseAddr),
    .texWidth   (texWidth),
    .texHeight  (texHeight),
    .texOffset  (texOffset),
    .vtxCount   (vtxCount),
    .lineWidth  (lineWidth),
    .vtxX       (vtxX),
    .vtxY       (vtxY),
    .errCode    (errCode)
  );

  assign vtxLast = vtxValid && remIsOne;

endmodule

// File: rtl/relvtx_decoder_chk.sv
module relvtx_decoder_chk #(
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               inReady,
  input logic               hdrValid,
  input logic               vtxValid,
  input logic               vtxReady,
  input logic [COORD_W-1:0] vtxX,
  input logic [COORD_W-1:0] vtxY,
  input logic               vtxLast,
  input logic               done,
  input logic               err
);

  // R10: input side stalled while a vertex is pending
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    vtxValid |-> !inReady);

  // R10: offered vertex held until taken
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (vtxValid && !vtxReady) |=> (vtxValid && $stable(vtxX) && $stable(vtxY) && $stable(vtxLast)));

  // R11: done only after the final vertex handshake
  a_r11_done_src: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(vtxValid && vtxReady && vtxLast));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: rejection never overlaps vertex output or completion
  a_r1_err_excl: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && !vtxValid && !hdrValid));

  // R12: reset leaves the block idle
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (inReady && !vtxValid && !done && !err && !hdrValid));

endmodule

bind relvtx_decoder relvtx_decoder_chk #(.COORD_W(COORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inReady  (inReady),
  .hdrValid (hdrValid),
  .vtxValid (vtxValid),
  .vtxReady (vtxReady),
  .vtxX     (vtxX),
  .vtxY     (vtxY),
  .vtxLast  (vtxLast),
  .done     (done),
  .err      (err)
);

// File: tb/relvtx_decoder_tb.sv
`timescale 1ns/1ps
module relvtx_decoder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [31:0] inData;
  logic        cmdAddrOdd;
  logic [15:0] startX, startY;
  logic        hdrValid;
  logic [15:0] modeFlags;
  logic [31:0] baseAddr;
  logic [11:0] texWidth, texHeight, texOffset;
  logic [15:0] vtxCount;
  logic [5:0]  lineWidth;
  logic        vtxValid, vtxReady;
  logic [15:0] vtxX, vtxY;
  logic        vtxLast, done, err;
  logic [7:0]  errCode;

  always #4 clk = ~clk;

  relvtx_decoder u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .cmdAddrOdd(cmdAddrOdd), .startX(startX), .startY(startY), .hdrValid(hdrValid),
    .modeFlags(modeFlags), .baseAddr(baseAddr), .texWidth(texWidth), .texHeight(texHeight),
    .texOffset(texOffset), .vtxCount(vtxCount), .lineWidth(lineWidth), .vtxValid(vtxValid),
    .vtxReady(vtxReady), .vtxX(vtxX), .vtxY(vtxY), .vtxLast(vtxLast), .done(done),
    .err(err), .errCode(errCode)
  );

  // displacement table: bytes low->high DY(k), DX(k), DY(k+1), DX(k+1)
  localparam logic [31:0] DTAB [6] = '{
    32'h7F01_80FF, 32'h0102_0304, 32'hFEFD_7F7F,
    32'h8080_0505, 32'h1020_F0E0, 32'hAA55_0A0B
  };
  localparam logic [15:0] MODE_OK = 16'h0011;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int vCount, doneCnt, lastVtxCyc, doneCyc, stallViol;
  logic [15:0] gotX [64];
  logic [15:0] gotY [64];
  logic        gotLast [64];
  logic        bpMode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // back-pressure driven away from both edges
  always @(posedge clk) begin
    #2;
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    vtxReady = bpMode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (vtxValid && inReady) stallViol++;
      if (vtxValid && vtxReady) begin
        if (vCount < 64) begin
          gotX[vCount]    = vtxX;
          gotY[vCount]    = vtxY;
          gotLast[vCount] = vtxLast;
        end
        vCount++;
        lastVtxCyc = cyc;
      end
      if (done) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  task automatic sendWord(input logic [31:0] w);
    inData  = w;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic sendHeader(input logic [15:0] mode, input logic [31:0] base, input logic odd,
                            input logic [11:0] tw, input logic [11:0] th, input logic [11:0] ofs,
                            input logic [15:0] n, input logic [5:0] lw,
                            input logic [15:0] sx, input logic [15:0] sy);
    cmdAddrOdd = odd;
    startX     = sx;
    startY     = sy;
    sendWord({8'hB6, 8'h00, mode});
    sendWord(base);
    sendWord({4'h0, tw, 4'h0, th});
    sendWord({4'h0, ofs, n});
    sendWord({26'h0, lw});
  endtask

  // header verdict due on the second edge after the line-width word
  task automatic expectVerdict(input logic [7:0] expCode, input string req);
    @(negedge clk);
    check(!err && !hdrValid, req, "verdict early", {err, hdrValid}, 0);
    @(negedge clk);
    if (expCode == 8'h00)
      check(hdrValid && !err, req, "hdrValid", {hdrValid, err}, 2);
    else
      check(err && !hdrValid && errCode == expCode, req, "errCode", errCode, expCode);
  endtask

  task automatic runBody(input int n, input logic [15:0] sx, input logic [15:0] sy,
                         input string req);
    logic [15:0] ex, ey, half;
    vCount  = 0;
    doneCnt = 0;
    for (int w = 0; w < (n + 1) / 2; w++) sendWord(DTAB[w]);
    for (int t = 0; t < 200 && doneCnt == 0; t++) @(negedge clk);
    @(negedge clk);
    check(vCount == n, "R9", {req, " vertex count"}, vCount, n);
    ex = sx;
    ey = sy;
    for (int k = 0; k < n && k < 64; k++) begin
      half = k[0] ? DTAB[k/2][31:16] : DTAB[k/2][15:0];
      ex   = ex + {{8{half[15]}}, half[15:8]};
      ey   = ey + {{8{half[7]}}, half[7:0]};
      check(gotX[k] == ex && gotY[k] == ey, "R8", {req, " vertex"},
            {gotX[k], gotY[k]}, {ex, ey});
      check(gotLast[k] == (k == n - 1), "R11", {req, " last flag"}, gotLast[k], k == n - 1);
    end
    check(doneCnt == 1 && doneCyc == lastVtxCyc + 1, "R11", {req, " done timing"},
          doneCyc - lastVtxCyc, 1);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inData = '0; cmdAddrOdd = 1'b0;
    startX = '0; startY = '0; vtxReady = 1'b1;
    vCount = 0; doneCnt = 0; stallViol = 0; lastVtxCyc = 0; doneCyc = 0;
    repeat (3) @(negedge clk);
    check(inReady && !vtxValid && !done && !err && !hdrValid, "R12", "reset state",
          {inReady, vtxValid, done, err, hdrValid}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);

    // R1: wrong opcode
    sendWord(32'h3600_0011);
    @(negedge clk);
    check(err && errCode == 8'h01, "R1", "bad opcode err", errCode, 8'h01);
    @(negedge clk);
    check(!err && inReady, "R1", "err pulse ends, idle", {err, inReady}, 2'b01);

    // command A: odd n, wrap around
    sendHeader(MODE_OK, 32'h0000_0103, 1'b1, 12'd16, 12'd4, 12'd15, 16'd11, 6'd5,
               16'h7FF0, 16'h8005);
    expectVerdict(8'h00, "R2");
    check(modeFlags == MODE_OK && baseAddr == 32'h103, "R2", "mode/base",
          {modeFlags, baseAddr}, {MODE_OK, 32'h103});
    check(texWidth == 16 && texHeight == 4 && texOffset == 15, "R2", "texture fields",
          {texWidth, texHeight, texOffset}, {12'd16, 12'd4, 12'd15});
    check(vtxCount == 11 && lineWidth == 5, "R2", "count/width",
          {vtxCount, lineWidth}, {16'd11, 6'd5});
    runBody(11, 16'h7FF0, 16'h8005, "odd n");

    // command B: even n, width/height upper bounds, back-pressure (R10)
    bpMode = 1'b1;
    sendHeader(MODE_OK, 32'h0000_0040, 1'b0, 12'd4088, 12'd4095, 12'd4087, 16'd12, 6'd63,
               16'h0010, 16'hFFF0);
    expectVerdict(8'h00, "R4");
    runBody(12, 16'h0010, 16'hFFF0, "R10 backpressure");
    bpMode = 1'b0;
    check(stallViol == 0, "R10", "inReady while vertex pending", stallViol, 0);

    // rejections
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd0, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h02, "R3");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd7, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h04, "R4");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd4089, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h04, "R4");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd0, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h04, "R4");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd4, 12'd16, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h08, "R4");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd2, 6'd1, 16'h0, 16'h0);
    expectVerdict(8'h10, "R5");
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd2, 12'd0, 16'd2, 6'd0, 16'h0, 16'h0);
    expectVerdict(8'h20, "R5");
    sendHeader(MODE_OK, 32'h3, 1'b0, 12'd16, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h40, "R6");
    sendHeader(16'h0019, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h80, "R7");
    sendHeader(16'h0010, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h80, "R7");
    sendHeader(16'h0001, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd2, 6'd5, 16'h0, 16'h0);
    expectVerdict(8'h80, "R7");

    // command C: n=1, flat line legal, minimum width, nonzero dummy half (R9)
    sendHeader(MODE_OK, 32'h0000_0007, 1'b1, 12'd8, 12'd1, 12'd7, 16'd1, 6'd0,
               16'h1234, 16'h4321);
    expectVerdict(8'h00, "R5");
    runBody(1, 16'h1234, 16'h4321, "single vertex");

    // R12: reset in the middle of a command
    sendHeader(MODE_OK, 32'h0, 1'b0, 12'd16, 12'd4, 12'd0, 16'd12, 6'd5, 16'h0, 16'h0);
    @(negedge clk);
    @(negedge clk);
    sendWord(DTAB[0]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(inReady && !vtxValid && !done && !err && !hdrValid, "R12", "mid-run reset",
          {inReady, vtxValid, done, err, hdrValid}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    sendHeader(MODE_OK, 32'h0000_0103, 1'b1, 12'd16, 12'd4, 12'd15, 16'd11, 6'd5,
               16'h7FF0, 16'h8005);
    expectVerdict(8'h00, "R12");
    runBody(11, 16'h7FF0, 16'h8005, "after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule